// File: doc/BRIEF.md
# Interleaved Block Fill Controller

This block services one cache-miss refill at a time from a main memory divided into four word-interleaved banks. A miss request carries an aligned block address. The controller places that address on a shared row bus for a single cycle and strobes the banks. It waits out the bank access time and then returns the four words of the block over a one-word response bus, one word per cycle, lowest word first. A completion pulse marks the last word. While a fill is in progress the block reports itself busy and ignores further requests.

A build parameter selects a second, non-interleaved arrangement for comparison. In that arrangement each word costs a full access followed by its own transfer cycle, so the fill takes 1 + 4×(L+1) cycles instead of 1 + L + 4, where L is the bank access latency (15 by default). The banks sit outside the block. Each bank is modelled as a fixed-latency read port whose data is valid L cycles after its strobe.

Top module: `blkfill_ctrl`

## Requirements
- R1: While reset is held and in the idle cycles after its release, `busy`, `rsp_valid`, `done` and every `bank_strobe` bit are 0.
- R2: In interleaved mode, in the cycle after a request is accepted (cycle 1), all four `bank_strobe` bits are 1 for that single cycle and `bank_row` equals the requested block address. No strobe is raised in any other cycle of the fill.
- R3: The word with in-block index w (word address = {block, w[1:0]}) is taken from bank w, which is read at row = block address. It is returned on `rsp_data`.
- R4: In interleaved mode with latency L, word k (k = 0..3) is delivered in cycle 2+L+k, counting the cycle after the request edge as cycle 1. For L = 15 the fill ends in cycle 20.
- R5: Exactly four words are delivered per fill, in ascending order. `rsp_valid` is high for each of them and `rsp_word` carries the index k.
- R6: `done` is a single-cycle pulse that coincides with the fourth word and with no other cycle.
- R7: `busy` is high from cycle 1 through the cycle of the last word, and low afterwards. A request raised while `busy` is high changes neither the words, their timing nor the strobes, and starts no extra fill.
- R8: In non-interleaved mode, cycle 1 strobes bank 0 only, and the transfer cycle of word k (k < 3) strobes bank k+1 only. Word k arrives in cycle 2+L+k×(L+1), so the fill ends in cycle 1+4×(L+1) (65 for L = 15).
- R9: A request raised in the cycle right after `done` is accepted, and `busy` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Miss request, sampled when idle |
| req_blk | input | BLK_AW | Aligned block address of the miss |
| busy | output | 1 | Fill in progress; requests ignored |
| bank_strobe | output | NBANK | Per-bank access start |
| bank_row | output | BLK_AW | Row address shared by all banks |
| bank_rdata | input | NBANK×DATA_W | Read data of all banks, bank 0 in the low slice |
| rsp_valid | output | 1 | A block word is on `rsp_data` |
| rsp_word | output | log2(NBANK) | Index of the word within the block |
| rsp_data | output | DATA_W | Returned word |
| done | output | 1 | Pulse with the last word of the fill |

## Verification
Every result is tied to a cycle number counted from the request edge. The strobes are due in cycle 1. Word k is due in cycle 17+k in interleaved mode and in cycle 17+16k in the one-bank-at-a-time mode. `done` is due with word 3, and `busy` drops in the cycle after it. The bench samples every output on the falling edge of every cycle from 1 to one past the last word and compares each one against those formulas. The bank models return a poison value until their latency has elapsed, so a word read even one cycle early fails the data comparison against the reference array. All 256 block addresses are swept in both modes. The fills run back to back, and stray requests are injected mid-fill and on the done cycle.

// File: rtl/blkfill_pkg.sv
// Package: shared types of the block fill controller.
// Assumes: nothing beyond IEEE 1800-2017.
package blkfill_pkg;

    // Sequencer phases: idle, address cycle, bank wait, word transfer.
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_ADDR = 2'd1,
        FS_WAIT = 2'd2,
        FS_XFER = 2'd3
    } fill_state_e;

endpackage

// File: rtl/lat_timer.sv
// Module: lat_timer
// Counts out the bank access latency. A load presets LAT-1; each
// decrement cycle steps down toward zero, and `zero` flags the last
// wait cycle. Assumes LAT >= 1 and that load and dec are never both high.
module lat_timer #(
    parameter int LAT   = 15,
    parameter int CNT_W = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic zero
);

    logic [CNT_W-1:0] cnt;

    // Preset on load, count down while waiting, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(LAT - 1);
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R4: the count stays put unless loaded or decremented.
    a_r4_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt));

    // R4: after a load the wait lasts LAT cycles, so zero is not seen at once unless LAT is 1.
    a_r4_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (zero == (LAT == 1)));

endmodule

// File: rtl/word_mux.sv
// Module: word_mux
// Picks the read data of the bank that holds the current block word.
// Assumes bank b occupies bits [b*DATA_W +: DATA_W] of the flat bus.
module word_mux #(
    parameter int NBANK  = 4,
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(NBANK)
) (
    input  logic [NBANK*DATA_W-1:0] bank_rdata,
    input  logic [SEL_W-1:0]        sel,
    output logic [DATA_W-1:0]       word
);

    logic [DATA_W-1:0] lane [NBANK];

    // Split the flat bank bus into one lane per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_lane
        assign lane[b] = bank_rdata[b*DATA_W +: DATA_W];
    end

    // Select the lane of the addressed bank.
    always_comb begin
        word = lane[sel];
    end

endmodule

// File: rtl/fill_seq.sv
// Module: fill_seq
// Phase sequencer of one block fill: accepts a request when idle, spends
// one address cycle, waits on the latency timer, then steps through the
// words. INTERLEAVE=1 starts every bank at once; INTERLEAVE=0 starts one
// bank per word, launching the next during the current transfer.
// Assumes NBANK is a power of two.
module fill_seq
    import blkfill_pkg::*;
#(
    parameter int NBANK      = 4,
    parameter bit INTERLEAVE = 1'b1,
    parameter int SEL_W      = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             timer_zero,
    output logic             accept,
    output logic             busy,
    output logic [NBANK-1:0] strobe,
    output logic             timer_load,
    output logic             timer_dec,
    output logic             rsp_valid,
    output logic [SEL_W-1:0] word_idx,
    output logic             done
);

    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NBANK - 1);

    fill_state_e      state;
    logic             last_word;
    logic             launch_next;
    logic [SEL_W-1:0] next_idx;

    assign last_word   = (word_idx == LAST_IDX);
    assign next_idx    = word_idx + 1'b1;
    assign accept      = (state == FS_IDLE) && req_valid;
    assign busy        = (state != FS_IDLE);
    assign rsp_valid   = (state == FS_XFER);
    assign done        = rsp_valid && last_word;
    assign launch_next = rsp_valid && !last_word && !INTERLEAVE;
    assign timer_load  = (state == FS_ADDR) || launch_next;
    assign timer_dec   = (state == FS_WAIT);

    // Phase and word index progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FS_IDLE;
            word_idx <= '0;
        end else begin
            case (state)
                FS_IDLE: if (req_valid) begin
                    state    <= FS_ADDR;
                    word_idx <= '0;
                end
                FS_ADDR: state <= FS_WAIT;
                FS_WAIT: if (timer_zero) state <= FS_XFER;
                FS_XFER: begin
                    if (last_word) begin
                        state <= FS_IDLE;
                    end else begin
                        word_idx <= next_idx;
                        if (!INTERLEAVE) state <= FS_WAIT;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Bank start pattern chosen by the organisation parameter.
    if (INTERLEAVE) begin : g_all_banks
        // All banks start together in the address cycle.
        always_comb begin
            strobe = (state == FS_ADDR) ? '1 : '0;
        end
    end else begin : g_one_bank
        // Bank 0 in the address cycle, then the next bank during each transfer.
        always_comb begin
            if (state == FS_ADDR)  strobe = NBANK'(1);
            else if (launch_next)  strobe = NBANK'(1) << next_idx;
            else                   strobe = '0;
        end

        // R8: never more than one bank started at a time.
        a_r8_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(strobe));
    end

    // R1: nothing is started or returned while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rsp_valid && strobe == '0));

    // R2: every bank start is followed by a wait phase.
    a_r2_strobe_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != '0) |=> (state == FS_WAIT));

    // R5: a non-final word is followed by the next index.
    a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !done) |=> (word_idx == $past(word_idx) + 1'b1));

    // R6: the done pulse is followed by idle.
    a_r6_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7: busy persists until the done cycle.
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: rtl/blkfill_ctrl.sv
// Module: blkfill_ctrl (top)
// Refills one cache block from NBANK word-interleaved banks: one address
// cycle, one shared bank access of ACC_LAT cycles, then one word per cycle
// on a one-word response bus. INTERLEAVE=0 models a single word-wide memory
// for comparison. Assumes the banks present read data ACC_LAT cycles after
// their strobe and hold it until strobed again.
module blkfill_ctrl
    import blkfill_pkg::*;
#(
    parameter int BLK_AW     = 8,
    parameter int DATA_W     = 32,
    parameter int NBANK      = 4,
    parameter int ACC_LAT    = 15,
    parameter bit INTERLEAVE = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [BLK_AW-1:0]          req_blk,
    output logic                       busy,
    output logic [NBANK-1:0]           bank_strobe,
    output logic [BLK_AW-1:0]          bank_row,
    input  logic [NBANK*DATA_W-1:0]    bank_rdata,
    output logic                       rsp_valid,
    output logic [$clog2(NBANK)-1:0]   rsp_word,
    output logic [DATA_W-1:0]          rsp_data,
    output logic                       done
);

    localparam int SEL_W = $clog2(NBANK);
    localparam int CNT_W = $clog2(ACC_LAT + 1);

    logic              accept;
    logic              timer_load;
    logic              timer_dec;
    logic              timer_zero;
    logic [BLK_AW-1:0] addr_q;

    // Capture the block address when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_blk;
        end
    end

    assign bank_row = addr_q;

    fill_seq #(
        .NBANK      (NBANK),
        .INTERLEAVE (INTERLEAVE),
        .SEL_W      (SEL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .timer_zero (timer_zero),
        .accept     (accept),
        .busy       (busy),
        .strobe     (bank_strobe),
        .timer_load (timer_load),
        .timer_dec  (timer_dec),
        .rsp_valid  (rsp_valid),
        .word_idx   (rsp_word),
        .done       (done)
    );

    lat_timer #(
        .LAT   (ACC_LAT),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .dec   (timer_dec),
        .zero  (timer_zero)
    );

    word_mux #(
        .NBANK  (NBANK),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_mux (
        .bank_rdata (bank_rdata),
        .sel        (rsp_word),
        .word       (rsp_data)
    );

    // R7: the captured address cannot change while a fill runs.
    a_r7_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(addr_q)));

    // R9: a request seen while idle always starts a fill.
    a_r9_idle_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

endmodule

// File: tb/sim_blkfill_ctrl.sv
// Bank model: a fixed-latency read port. Data is valid LAT cycles after
// the strobe edge and held until the next strobe; otherwise a poison value.
module sim_bank_model #(
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int NB      = 4,
    parameter int LAT     = 15,
    parameter int BANK_ID = 0
) (
    input  logic          clk,
    input  logic          strobe,
    input  logic [AW-1:0] row,
    output logic [DW-1:0] rdata
);
    logic [AW-1:0] row_q;
    int            rem;
    logic          loaded;

    initial begin
        rem    = 0;
        loaded = 1'b0;
        row_q  = '0;
    end

    always @(posedge clk) begin
        if (strobe) begin
            rem    <= LAT;
            row_q  <= row;
            loaded <= 1'b1;
        end else if (rem != 0) begin
            rem <= rem - 1;
        end
    end

    always_comb begin
        if (loaded && rem == 0)
            rdata = DW'((int'(row_q) * NB + BANK_ID) * 32'h0100_0193) ^ DW'(32'h5A5A_0000);
        else
            rdata = DW'(32'hDEAD_0000 | BANK_ID);
    end
endmodule

module sim_blkfill_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam int NB  = 4;
    localparam int LAT = 15;
    localparam int NWORDS = (1 << AW) * NB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          req_v0 = 1'b0, req_v1 = 1'b0;
    logic [AW-1:0] req_a0 = '0, req_a1 = '0;
    logic          busy0, busy1, rv0, rv1, dn0, dn1;
    logic [NB-1:0] stb0, stb1;
    logic [AW-1:0] row0, row1;
    logic [NB*DW-1:0] rdat0, rdat1;
    logic [1:0]    rw0, rw1;
    logic [DW-1:0] rd0, rd1;
    logic [DW-1:0] bo0 [NB];
    logic [DW-1:0] bo1 [NB];

    logic [DW-1:0] ref_mem [NWORDS];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    blkfill_ctrl #(.BLK_AW(AW), .DATA_W(DW), .NBANK(NB), .ACC_LAT(LAT), .INTERLEAVE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_v0), .req_blk(req_a0), .busy(busy0),
        .bank_strobe(stb0), .bank_row(row0), .bank_rdata(rdat0), .rsp_valid(rv0),
        .rsp_word(rw0), .rsp_data(rd0), .done(dn0));

    blkfill_ctrl #(.BLK_AW(AW), .DATA_W(DW), .NBANK(NB), .ACC_LAT(LAT), .INTERLEAVE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_v1), .req_blk(req_a1), .busy(busy1),
        .bank_strobe(stb1), .bank_row(row1), .bank_rdata(rdat1), .rsp_valid(rv1),
        .rsp_word(rw1), .rsp_data(rd1), .done(dn1));

    for (genvar b = 0; b < NB; b++) begin : g_banks
        sim_bank_model #(.AW(AW), .DW(DW), .NB(NB), .LAT(LAT), .BANK_ID(b)) bk0 (
            .clk(clk), .strobe(stb0[b]), .row(row0), .rdata(bo0[b]));
        sim_bank_model #(.AW(AW), .DW(DW), .NB(NB), .LAT(LAT), .BANK_ID(b)) bk1 (
            .clk(clk), .strobe(stb1[b]), .row(row1), .rdata(bo1[b]));
        assign rdat0[b*DW +: DW] = bo0[b];
        assign rdat1[b*DW +: DW] = bo1[b];
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic set_req(input int m, input logic v, input logic [AW-1:0] a);
        if (m == 0) begin req_v0 = v; req_a0 = a; end
        else        begin req_v1 = v; req_a1 = a; end
    endtask

    // One fill on instance m; entered just after a falling edge (cycle 0).
    task automatic fill(input int m, input int blk);
        int first  = 2 + LAT;
        int stride = (m == 0) ? 1 : LAT + 1;
        int last   = first + 3 * stride;
        string tq  = (m == 0) ? "R4" : "R8";
        set_req(m, 1'b1, AW'(blk));
        @(posedge clk);
        @(negedge clk);
        set_req(m, 1'b0, AW'(blk));
        for (int c = 1; c <= last + 1; c++) begin
            logic          s_busy, s_rv, s_dn;
            logic [NB-1:0] s_stb, e_stb;
            logic [AW-1:0] s_row;
            logic [1:0]    s_rw;
            logic [DW-1:0] s_rd;
            bit            e_v;
            int            k;
            s_busy = (m == 0) ? busy0 : busy1;
            s_rv   = (m == 0) ? rv0   : rv1;
            s_dn   = (m == 0) ? dn0   : dn1;
            s_stb  = (m == 0) ? stb0  : stb1;
            s_row  = (m == 0) ? row0  : row1;
            s_rw   = (m == 0) ? rw0   : rw1;
            s_rd   = (m == 0) ? rd0   : rd1;
            e_v = (c >= first) && ((c - first) % stride == 0) && (c <= last);
            k   = (c - first) / stride;
            chk({tq, " R5 word valid"}, 32'(s_rv), 32'(e_v));
            if (e_v && s_rv) begin
                chk("R3 word data", s_rd, ref_mem[blk * NB + k]);
                chk("R5 word index", 32'(s_rw), 32'(k));
            end
            chk("R6 done pulse", 32'(s_dn), 32'(c == last));
            chk("R7 busy window", 32'(s_busy), 32'(c <= last));
            if (c == 1) chk("R9 request accepted", 32'(s_busy), 32'd1);
            if (m == 0) e_stb = (c == 1) ? 4'hF : 4'h0;
            else if (c == 1) e_stb = 4'h1;
            else if (e_v && k < 3) e_stb = NB'(1) << (k + 1);
            else e_stb = 4'h0;
            chk((m == 0) ? "R2 bank strobes" : "R8 bank strobes", 32'(s_stb), 32'(e_stb));
            if (s_stb != 0) chk("R2 row address", 32'(s_row), 32'(blk));
            // R7: stray requests mid-fill and on the done cycle.
            if (c == 5 || c == last) set_req(m, 1'b1, ~AW'(blk));
            if (c == 6 || c == last + 1) set_req(m, 1'b0, AW'(blk));
            if (c <= last) @(negedge clk);
        end
    endtask

    initial begin
        for (int a = 0; a < NWORDS; a++)
            ref_mem[a] = DW'(a * 32'h0100_0193) ^ DW'(32'h5A5A_0000);
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        // R1: quiet outputs under reset and just after release.
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'({busy0, busy1}), 32'd0);
        chk("R1 valid in reset", 32'({rv0, rv1, dn0, dn1}), 32'd0);
        chk("R1 strobes in reset", 32'({stb0, stb1}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 busy after reset", 32'({busy0, busy1}), 32'd0);
        chk("R1 outputs after reset", 32'({rv0, rv1, dn0, dn1, stb0, stb1}), 32'd0);
        // Interleaved sweep over every block, back to back (R2-R7, R9).
        for (int blk = 0; blk < (1 << AW); blk++) fill(0, blk);
        // Non-interleaved sweep over every block (R8).
        for (int blk = 0; blk < (1 << AW); blk++) fill(1, blk);
        @(negedge clk);
        chk("R7 idle after sweep", 32'({busy0, busy1}), 32'd0);
        summary();
    end
endmodule